// File: doc/BRIEF.md
# Circular-buffer DMA address engine

This block is the address side of one DMA channel sitting between a serial byte stream and memory. Software programs a 64K segment number, a buffer base, an exclusive buffer bound, a starting pointer and a byte count. Bytes then flow through a four-entry staging FIFO. In the default receive build, the serial side pushes bytes in and the channel writes them to memory. In the transmit build, the channel reads bytes from memory and the serial side drains them.

Each acknowledged memory transfer moves the pointer forward by one. When the incremented pointer equals the bound, the pointer is reloaded with the base value in its high byte and zero in its low byte, so the ring always restarts on a 256-byte boundary and the bound address itself is never touched. Every transfer also decrements the byte count. A transfer taken while the count is already zero latches a sticky flag, which drives the interrupt output when the interrupt is enabled.

Registers are reached through a single-cycle write strobe and a combinational read port. Memory traffic uses a request that is held until acknowledged. The channel's 24-bit memory address is the segment byte followed by the 16-bit pointer.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset every register reads zero, except status, which reads 0x0002 (FIFO empty). mem_req and irq are low.
- R2: mem_req is high exactly when the enable bit (control register 0, bit 0) is set and the FIFO holds at least one byte. mem_addr is {segment (reg 2), pointer (reg 5)}, and mem_we is 1 in the receive build.
- R3: A transfer (mem_req and mem_ack high at a clock edge) advances the pointer by one. If the incremented value equals the bound (reg 4), the pointer becomes {base (reg 3), 8'h00} instead.
- R4: Each transfer decrements the byte count (reg 6). A transfer taken while the count is 0 leaves the count at 0xFFFF and sets the sticky flag (status reg 1, bit 0).
- R5: irq equals the sticky flag ANDed with the interrupt enable (control bit 1).
- R6: Writing status with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it. When a set and a clear fall in the same cycle, the flag ends up set. Status bits 1 and 2 read FIFO empty and FIFO full.
- R7: While the enable bit is clear, no request is issued and mem_ack leaves the pointer and count unchanged.
- R8: ser_in_ready is high while the FIFO holds fewer than 4 bytes. A byte is accepted when ser_in_valid and ser_in_ready are both high. mem_wdata always presents the oldest stored byte, so bytes reach memory in arrival order.
- R9: Register 7 reads {byte 1, byte 0} and register 8 reads {byte 3, byte 2}, where byte 0 is the oldest stored byte and sits in the low half. Positions beyond the stored count read zero.
- R10: A software write to the pointer or count in the same cycle as a transfer takes effect, and the transfer's own update of that register is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write (receive), 0 = memory read (transmit) |
| mem_addr | output | 24 | {segment, pointer} |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory (transmit build) |
| mem_ack | input | 1 | Memory acknowledge, completes a transfer |
| ser_in_valid | input | 1 | Serial byte offered (receive build) |
| ser_in_data | input | 8 | Serial byte in |
| ser_in_ready | output | 1 | FIFO can accept a serial byte |
| ser_out_valid | output | 1 | Byte available to serial side (transmit build) |
| ser_out_data | output | 8 | Byte to serial side |
| ser_out_ready | input | 1 | Serial side takes the byte |
| irq | output | 1 | Interrupt: flag and enable |

## Verification
Two pairs of functions can collide in one clock. A terminal-count transfer can set the flag in the same cycle that software writes one to clear it. A transfer can update the pointer or count in the same cycle that software writes that register. The bench provokes both by raising mem_ack together with the register write while a request is pending. It then reads back status, pointer and count, expecting the flag set and the software values kept. Wrap-around coinciding with the terminal count is exercised by a three-transfer ring, and a long random phase mixes serial pushes, memory acknowledges, pushes into a full FIFO and enable changes against a cycle-by-cycle model.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  typedef enum logic [3:0] {
    REG_CTRL    = 4'd0,
    REG_STAT    = 4'd1,
    REG_SEG     = 4'd2,
    REG_BASE    = 4'd3,
    REG_BOUND   = 4'd4,
    REG_PTR     = 4'd5,
    REG_CNT     = 4'd6,
    REG_PEEK_LO = 4'd7,
    REG_PEEK_HI = 4'd8
  } reg_sel_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IE_BIT    = 1;
  localparam int STAT_FLAG_BIT  = 0;
  localparam int STAT_EMPTY_BIT = 1;
  localparam int STAT_FULL_BIT  = 2;

endpackage

// File: rtl/ring_dma_fifo.sv
module ring_dma_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  output logic [DW-1:0]   head,
  output logic            empty,
  output logic            full,
  output logic [4*DW-1:0] peek
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wr_idx_q, wr_idx_d;
  logic [IW-1:0] rd_idx_q, rd_idx_d;
  logic [LW-1:0] level_q, level_d;
  logic          idx_en;

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    if (push) wr_idx_d = (wr_idx_q == IW'(DEPTH - 1)) ? '0 : wr_idx_q + 1'b1;
    if (pop)  rd_idx_d = (rd_idx_q == IW'(DEPTH - 1)) ? '0 : rd_idx_q + 1'b1;
    level_d = level_q + LW'(push) - LW'(pop);
    idx_en  = push || pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      level_q  <= '0;
    end else if (idx_en) begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx_q] <= push_data;
  end

  assign head  = mem[rd_idx_q];
  assign empty = (level_q == '0);
  assign full  = (level_q == LW'(DEPTH));

  for (genvar i = 0; i < 4; i++) begin : g_peek
    logic [IW:0]   sum;
    logic [IW-1:0] idx;
    assign sum = {1'b0, rd_idx_q} + (IW+1)'(i);
    assign idx = (sum >= (IW+1)'(DEPTH)) ? IW'(sum - (IW+1)'(DEPTH)) : sum[IW-1:0];
    assign peek[i*DW +: DW] = (LW'(i) < level_q) ? mem[idx] : '0;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R2
  AST_FIFO_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty); // R8

endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              xfer,
  output logic              en,
  output logic              ie,
  output logic              flag,
  output logic [SEG_W-1:0]  seg,
  output logic [ADDR_W-9:0] base,
  output logic [ADDR_W-1:0] bound,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] cnt
);

  localparam int BASE_W = ADDR_W - 8;

  logic              en_q, ie_q, flag_q, flag_d;
  logic [SEG_W-1:0]  seg_q;
  logic [BASE_W-1:0] base_q;
  logic [ADDR_W-1:0] bound_q, ptr_q, cnt_q, ptr_d, cnt_d;
  logic [ADDR_W-1:0] ptr_inc, ptr_wrap;
  logic              ctrl_we, seg_we, base_we, bound_we, ptr_en, cnt_en, flag_en;
  logic              set_flag, clr_flag;

  always_comb begin
    ptr_inc  = ptr_q + 1'b1;
    ptr_wrap = (ptr_inc == bound_q) ? {base_q, 8'h00} : ptr_inc;

    ctrl_we  = wr_en && (wr_sel == REG_CTRL);
    seg_we   = wr_en && (wr_sel == REG_SEG);
    base_we  = wr_en && (wr_sel == REG_BASE);
    bound_we = wr_en && (wr_sel == REG_BOUND);
    ptr_en   = xfer || (wr_en && (wr_sel == REG_PTR));
    cnt_en   = xfer || (wr_en && (wr_sel == REG_CNT));

    ptr_d = (wr_en && (wr_sel == REG_PTR)) ? wr_data : ptr_wrap;
    cnt_d = (wr_en && (wr_sel == REG_CNT)) ? wr_data : cnt_q - 1'b1;

    set_flag = xfer && (cnt_q == '0);
    clr_flag = wr_en && (wr_sel == REG_STAT) && wr_data[STAT_FLAG_BIT];
    flag_d   = set_flag ? 1'b1 : (clr_flag ? 1'b0 : flag_q);
    flag_en  = set_flag || clr_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      seg_q   <= '0;
      base_q  <= '0;
      bound_q <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (ctrl_we) begin
        en_q <= wr_data[CTRL_EN_BIT];
        ie_q <= wr_data[CTRL_IE_BIT];
      end
      if (seg_we)   seg_q   <= wr_data[SEG_W-1:0];
      if (base_we)  base_q  <= wr_data[BASE_W-1:0];
      if (bound_we) bound_q <= wr_data;
      if (ptr_en)   ptr_q   <= ptr_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (flag_en)  flag_q  <= flag_d;
    end
  end

  assign en    = en_q;
  assign ie    = ie_q;
  assign flag  = flag_q;
  assign seg   = seg_q;
  assign base  = base_q;
  assign bound = bound_q;
  assign ptr   = ptr_q;
  assign cnt   = cnt_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !wr_en) |=> $stable(ptr_q) && $stable(cnt_q)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && wr_sel == REG_STAT)) |=> flag_q); // R6
  AST_TERMINAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cnt_q == '0) |=> flag_q); // R4
  AST_WRAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en && ptr_inc == bound_q) |=> (ptr_q[7:0] == 8'h00)); // R3

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 8,
  parameter int DW      = 8,
  parameter int DEPTH   = 4,
  parameter bit TX_MODE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [3:0]              reg_addr,
  input  logic [ADDR_W-1:0]       reg_wdata,
  output logic [ADDR_W-1:0]       reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [SEG_W+ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_ack,
  input  logic                    ser_in_valid,
  input  logic [DW-1:0]           ser_in_data,
  output logic                    ser_in_ready,
  output logic                    ser_out_valid,
  output logic [DW-1:0]           ser_out_data,
  input  logic                    ser_out_ready,
  output logic                    irq
);

  localparam int BASE_W = ADDR_W - 8;

  logic rst_q0, rst_q1, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q0 <= 1'b0;
      rst_q1 <= 1'b0;
    end else begin
      rst_q0 <= 1'b1;
      rst_q1 <= rst_q0;
    end
  end
  assign rst_s = rst_q1;

  logic              en, ie, flag;
  logic [SEG_W-1:0]  seg;
  logic [BASE_W-1:0] base;
  logic [ADDR_W-1:0] bound, ptr, cnt;
  logic              xfer, avail;
  logic              f_push, f_pop, f_empty, f_full;
  logic [DW-1:0]     f_wdata, f_head;
  logic [4*DW-1:0]   f_peek;
  logic              unused_in;

  assign mem_req = en && avail;
  assign xfer    = mem_req && mem_ack;

  ring_dma_regs #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (reg_wr),
    .wr_sel  (reg_addr),
    .wr_data (reg_wdata),
    .xfer    (xfer),
    .en      (en),
    .ie      (ie),
    .flag    (flag),
    .seg     (seg),
    .base    (base),
    .bound   (bound),
    .ptr     (ptr),
    .cnt     (cnt)
  );

  ring_dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_s),
    .push      (f_push),
    .push_data (f_wdata),
    .pop       (f_pop),
    .head      (f_head),
    .empty     (f_empty),
    .full      (f_full),
    .peek      (f_peek)
  );

  if (TX_MODE) begin : g_tx
    assign f_push        = xfer;
    assign f_wdata       = mem_rdata;
    assign f_pop         = ser_out_valid && ser_out_ready;
    assign avail         = !f_full;
    assign mem_we        = 1'b0;
    assign mem_wdata     = '0;
    assign ser_in_ready  = 1'b0;
    assign ser_out_valid = !f_empty;
    assign ser_out_data  = f_head;
    assign unused_in     = ^{ser_in_valid, ser_in_data};
  end else begin : g_rx
    assign f_push        = ser_in_valid && ser_in_ready;
    assign f_wdata       = ser_in_data;
    assign f_pop         = xfer;
    assign avail         = !f_empty;
    assign mem_we        = 1'b1;
    assign mem_wdata     = f_head;
    assign ser_in_ready  = !f_full;
    assign ser_out_valid = 1'b0;
    assign ser_out_data  = '0;
    assign unused_in     = ^{mem_rdata, ser_out_ready};
  end

  assign mem_addr = {seg, ptr};
  assign irq      = flag && ie;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: begin
        reg_rdata[CTRL_EN_BIT] = en;
        reg_rdata[CTRL_IE_BIT] = ie;
      end
      REG_STAT: begin
        reg_rdata[STAT_FLAG_BIT]  = flag;
        reg_rdata[STAT_EMPTY_BIT] = f_empty;
        reg_rdata[STAT_FULL_BIT]  = f_full;
      end
      REG_SEG:     reg_rdata[SEG_W-1:0]  = seg;
      REG_BASE:    reg_rdata[BASE_W-1:0] = base;
      REG_BOUND:   reg_rdata = bound;
      REG_PTR:     reg_rdata = ptr;
      REG_CNT:     reg_rdata = cnt;
      REG_PEEK_LO: reg_rdata[2*DW-1:0] = f_peek[2*DW-1:0];
      REG_PEEK_HI: reg_rdata[2*DW-1:0] = f_peek[4*DW-1:2*DW];
      default:     reg_rdata = '0;
    endcase
  end

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_s)
    mem_req |-> en); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && !mem_ack && !reg_wr) |=> (!mem_req || $stable(mem_addr))); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_s)
    irq |-> flag); // R5

endmodule

// File: tb/ring_dma_chan_test.sv
module ring_dma_chan_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        ser_in_valid, ser_in_ready;
  logic [7:0]  ser_in_data;
  logic        ser_out_valid, ser_out_ready;
  logic [7:0]  ser_out_data;
  logic        irq;

  always #10 clk = ~clk;

  ring_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .ser_in_valid(ser_in_valid),
    .ser_in_data(ser_in_data), .ser_in_ready(ser_in_ready),
    .ser_out_valid(ser_out_valid), .ser_out_data(ser_out_data),
    .ser_out_ready(ser_out_ready), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0]  q[$];
  logic        m_en, m_ie, m_flag;
  logic [7:0]  m_seg, m_base;
  logic [15:0] m_bound, m_ptr, m_cnt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] qat(input int i);
    return (i < q.size()) ? q[i] : 8'h00;
  endfunction

  function automatic logic [15:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return {14'd0, m_ie, m_en};
      4'd1: return {13'd0, (q.size() == 4), (q.size() == 0), m_flag};
      4'd2: return {8'd0, m_seg};
      4'd3: return {8'd0, m_base};
      4'd4: return m_bound;
      4'd5: return m_ptr;
      4'd6: return m_cnt;
      4'd7: return {qat(1), qat(0)};
      4'd8: return {qat(3), qat(2)};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tagof(input logic [3:0] a);
    case (a)
      4'd1: return "R6";
      4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7, 4'd8: return "R9";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_en = 0; m_ie = 0; m_flag = 0;
      m_seg = 0; m_base = 0; m_bound = 0; m_ptr = 0; m_cnt = 0;
    end else begin
      bit req, xfer, push_ok, setf;
      logic [15:0] nptr, ncnt;
      req     = m_en && (q.size() > 0);
      xfer    = req && mem_ack;
      push_ok = ser_in_valid && (q.size() < 4);
      setf    = 0;
      nptr    = m_ptr;
      ncnt    = m_cnt;
      if (xfer) begin
        void'(q.pop_front());
        nptr = m_ptr + 16'd1;
        if (nptr == m_bound) nptr = {m_base, 8'h00};
        ncnt = m_cnt - 16'd1;
        if (m_cnt == 16'd0) setf = 1;
      end
      if (push_ok) q.push_back(ser_in_data);
      if (reg_wr) begin
        case (reg_addr)
          4'd0: begin m_en = reg_wdata[0]; m_ie = reg_wdata[1]; end
          4'd1: if (reg_wdata[0]) m_flag = 0;
          4'd2: m_seg = reg_wdata[7:0];
          4'd3: m_base = reg_wdata[7:0];
          4'd4: m_bound = reg_wdata;
          4'd5: nptr = reg_wdata;
          4'd6: ncnt = reg_wdata;
          default: ;
        endcase
      end
      if (setf) m_flag = 1;
      m_ptr = nptr;
      m_cnt = ncnt;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      bit req;
      req = m_en && (q.size() > 0);
      chk(mem_req == req, "R2 mem_req", {31'd0, mem_req}, {31'd0, req});
      chk(mem_we == 1'b1, "R2 mem_we", {31'd0, mem_we}, 32'd1);
      if (req) begin
        chk(mem_addr == {m_seg, m_ptr}, "R3 mem_addr", {8'd0, mem_addr}, {8'd0, m_seg, m_ptr});
        chk(mem_wdata == q[0], "R8 mem_wdata", {24'd0, mem_wdata}, {24'd0, q[0]});
      end
      chk(ser_in_ready == (q.size() < 4), "R8 ser_in_ready", {31'd0, ser_in_ready}, {31'd0, (q.size() < 4)});
      chk(irq == (m_flag && m_ie), "R5 irq", {31'd0, irq}, {31'd0, (m_flag && m_ie)});
      chk(reg_rdata == mread(reg_addr), tagof(reg_addr), {16'd0, reg_rdata}, {16'd0, mread(reg_addr)});
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    #1;
    chk(reg_rdata == exp, tag, {16'd0, reg_rdata}, {16'd0, exp});
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    mem_ack = 0; mem_rdata = 0; ser_in_valid = 0; ser_in_data = 0; ser_out_ready = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    cmp_on = 1;

    // R1: reset state
    for (int a = 0; a < 9; a++) rdchk(4'(a), (a == 1) ? 16'h0002 : 16'h0000, "R1 reset value");
    chk(mem_req == 0, "R1 mem_req", {31'd0, mem_req}, 0);
    chk(irq == 0, "R1 irq", {31'd0, irq}, 0);

    wr(4'd2, 16'h0012);
    wr(4'd3, 16'h0030);
    wr(4'd4, 16'h3003);
    wr(4'd5, 16'h3000);
    wr(4'd6, 16'h0002);
    wr(4'd0, 16'h0002);

    // R8: fill beyond depth
    ser_in_valid = 1;
    for (int i = 0; i < 5; i++) begin
      ser_in_data = 8'hA1 + 8'(i);
      tick();
    end
    ser_in_valid = 0;
    chk(ser_in_ready == 0, "R8 full", {31'd0, ser_in_ready}, 0);
    rdchk(4'd7, 16'hA2A1, "R9 peek low");
    rdchk(4'd8, 16'hA4A3, "R9 peek high");

    // R7: acknowledge while disabled
    mem_ack = 1;
    repeat (5) tick();
    chk(mem_req == 0, "R7 no request", {31'd0, mem_req}, 0);
    mem_ack = 0;
    rdchk(4'd5, 16'h3000, "R7 pointer held");
    rdchk(4'd6, 16'h0002, "R7 count held");

    // R3/R4: three transfers, wrap at bound, terminal count
    wr(4'd0, 16'h0003);
    mem_ack = 1;
    repeat (3) tick();
    mem_ack = 0;
    rdchk(4'd5, 16'h3000, "R3 wrapped to base");
    rdchk(4'd6, 16'hFFFF, "R4 count past zero");
    rdchk(4'd1, 16'h0001, "R4 flag set");
    chk(irq == 1, "R5 irq on", {31'd0, irq}, 1);
    rdchk(4'd7, 16'h00A4, "R9 beyond level zero");

    wr(4'd0, 16'h0001);
    chk(irq == 0, "R5 irq masked", {31'd0, irq}, 0);

    // R6: write-one-to-clear
    wr(4'd1, 16'h0000);
    rdchk(4'd1, 16'h0001, "R6 write zero keeps");
    wr(4'd1, 16'h0001);
    rdchk(4'd1, 16'h0000, "R6 write one clears");

    // R6: set and clear in same cycle
    wr(4'd6, 16'h0000);
    reg_wr = 1; reg_addr = 4'd1; reg_wdata = 16'h0001; mem_ack = 1;
    tick();
    reg_wr = 0; mem_ack = 0;
    rdchk(4'd1, 16'h0003, "R6 set wins");

    // R10: software write collides with transfer
    ser_in_valid = 1; ser_in_data = 8'hB1; tick(); ser_in_valid = 0;
    reg_wr = 1; reg_addr = 4'd5; reg_wdata = 16'h1234; mem_ack = 1;
    tick();
    reg_wr = 0; mem_ack = 0;
    rdchk(4'd5, 16'h1234, "R10 pointer write wins");
    ser_in_valid = 1; ser_in_data = 8'hB2; tick(); ser_in_valid = 0;
    reg_wr = 1; reg_addr = 4'd6; reg_wdata = 16'h0010; mem_ack = 1;
    tick();
    reg_wr = 0; mem_ack = 0;
    rdchk(4'd6, 16'h0010, "R10 count write wins");

    // mixed traffic against the model
    wr(4'd4, 16'h3100);
    wr(4'd5, 16'h30F0);
    wr(4'd6, 16'h0014);
    wr(4'd0, 16'h0003);
    for (int i = 0; i < 600; i++) begin
      ser_in_valid = 1'($urandom_range(0, 1));
      ser_in_data  = 8'($urandom);
      mem_ack      = ($urandom_range(0, 3) != 0);
      reg_addr     = 4'($urandom_range(0, 8));
      if (i % 97 == 50) begin
        reg_wr = 1; reg_addr = 4'd0; reg_wdata = {14'd0, 1'b1, (i % 2 == 0)};
      end else if (i % 89 == 30) begin
        reg_wr = 1; reg_addr = 4'd1; reg_wdata = 16'h0001;
      end
      tick();
      reg_wr = 0;
    end
    ser_in_valid = 0; mem_ack = 0;
    repeat (3) tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule